// File: doc/BRIEF.md
# Compressed Stream Item Parser

This block is the front end of a dictionary-style decompressor. It accepts the compressed byte stream one byte per clock through a valid/ready handshake. Each block in the stream opens with a fixed header giving the decompressed size and a compressed/stored flag. The parser then sorts every following byte into one of four item kinds for the stages behind it: a literal byte, a copy descriptor made of a table index and a length code, a control byte that carries flag bits, or an end marker for an empty block. It keeps counting the output bytes that the items stand for and marks the item that completes the block. When the block is stored rather than compressed, it passes the bytes through as literals.

Control bytes reach the output only so that later stages can recognise them and skip them. The parser also keeps a short history of the most recent data bytes. Control and header bytes do not enter this history, so the bytes that came before a control word are still available once the control word has passed.

The controller is a single state machine. S_CLEAR is the one-cycle initialisation after reset and always moves to S_SEEK. In S_SEEK the parser drops bytes until it sees a start-of-block flag, and any state except S_CLEAR moves to S_HDR on such a byte. S_HDR moves to S_SEEK for a zero size, to S_RAW for a stored block, and to S_CTL for a compressed block. S_CTL moves to S_ITEM after the last control byte. S_ITEM moves to S_COPY2 on a copy flag. After each finished item, S_ITEM and S_COPY2 go back to S_ITEM, return to S_CTL once the flag word is used up, or move to S_SEEK when the block completes. S_RAW moves to S_SEEK when the block completes.

Top module: `stream_item_parser`

## Requirements
- R1: From reset the parser spends exactly one clock in its clear state with in_ready low. It then holds in_ready high, and it produces no item during or directly after reset.
- R2: A byte accepted with in_sof high is header byte 0, and every header is 8 bytes long. The output size is bytes 0 and 1, read little-endian. Bit 0 of byte 2 is 1 for a compressed block and 0 for a stored one. All other header bits are ignored, and header bytes produce no item.
- R3: A literal item carries the accepted byte unchanged on out_byte, with out_kind = 0.
- R4: In a compressed block, each flag group starts with 2 control bytes, and the first of them supplies flag bits 7:0. Each control byte comes out as an item with out_kind = 2 carrying that byte.
- R5: Flag bits are used LSB first, one per item. A 0 selects a 1-byte literal (kind 0) and a 1 selects a 2-byte copy. After 16 items a new pair of control bytes follows.
- R6: A copy is two bytes. The first byte holds the length code in bits 7:4 and index bits 11:8 in bits 3:0, and the second byte holds index bits 7:0. One item with out_kind = 1 comes out on the second byte, carrying out_index and out_len.
- R7: A literal counts 1 output byte and a copy counts its length code plus 3. out_eob is high on the item at which the count first reaches or passes the header size, even when that item falls in the middle of a group.
- R8: After the end of a block, bytes without in_sof produce no item and leave the history unchanged.
- R9: A byte with in_sof restarts header decoding from any state, and the partial block is abandoned.
- R10: A header size of 0 produces a single item with out_kind = 3 and out_eob high, on the last header byte.
- R11: hist_bytes holds the 5 most recent data bytes of the current block (literals and both bytes of each copy), newest in bits 7:0. Header and control bytes are excluded, and the history is cleared to zero at start of block.
- R12: An item appears in the cycle after its byte is accepted, and cycles with in_valid low produce no item.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Parser can accept a byte |
| in_data | input | 8 | Compressed stream byte |
| in_sof | input | 1 | Byte is the first of a block |
| out_valid | output | 1 | Item valid for this cycle |
| out_kind | output | 2 | 0 literal, 1 copy, 2 control, 3 empty-block end |
| out_byte | output | 8 | Literal or control byte |
| out_index | output | 12 | Copy table index |
| out_len | output | 4 | Copy length code |
| out_eob | output | 1 | Item completes the block |
| hist_bytes | output | 40 | Last 5 data bytes, newest in bits 7:0 |

## Verification
If the flag-bit pointer or the control-byte count goes wrong, items show up with the wrong kind. The error is visible at the first item after the fault, and a shifted group boundary shows it within at most 17 bytes. An output counter that is off produces out_eob one item early or late, or not at all. The bench then sees either missing items or items that arrive after the end-of-block. History corruption appears on hist_bytes as soon as the next data byte has been accepted. Because the bench checks each accepted byte the cycle after it is taken, each of these faults points to the exact byte that exposed it.

// File: rtl/sip_pkg.sv
`timescale 1ns/1ps
package sip_pkg;

    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned LEN_CODE_W = 4;
    localparam int unsigned INDEX_W    = 12;
    localparam int unsigned MIN_COPY   = 3;

    typedef enum logic [1:0] {
        K_LIT  = 2'd0,
        K_COPY = 2'd1,
        K_CTRL = 2'd2,
        K_END  = 2'd3
    } item_kind_e;

    typedef enum logic [2:0] {
        S_CLEAR,
        S_SEEK,
        S_HDR,
        S_CTL,
        S_ITEM,
        S_COPY2,
        S_RAW
    } parse_state_e;

endpackage

// File: rtl/sip_header.sv
`timescale 1ns/1ps
module sip_header #(
    parameter int unsigned HDR_BYTES  = 8,
    parameter int unsigned SIZE_BYTES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take,
    input  logic                    first,
    input  logic [7:0]              byte_in,
    output logic                    last,
    output logic [8*SIZE_BYTES-1:0] size_o,
    output logic                    compressed_o
);
    localparam int unsigned IDX_W  = $clog2(HDR_BYTES);
    localparam int unsigned SIZE_W = 8 * SIZE_BYTES;

    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  pos;
    logic [SIZE_W-1:0] size_q;
    logic              comp_q;

    assign pos  = first ? '0 : idx_q;
    assign last = !first && (idx_q == IDX_W'(HDR_BYTES - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            size_q <= '0;
            comp_q <= 1'b0;
        end else if (take) begin
            if (first) begin
                idx_q  <= IDX_W'(1);
                size_q <= SIZE_W'(byte_in);
                comp_q <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
                for (int b = 1; b < SIZE_BYTES; b++) begin
                    if (pos == IDX_W'(b)) begin
                        size_q[8*b +: 8] <= byte_in;
                    end
                end
                if (pos == IDX_W'(SIZE_BYTES)) begin
                    comp_q <= byte_in[0];
                end
            end
        end
    end

    assign size_o       = size_q;
    assign compressed_o = comp_q;

    // R2: a non-leading header byte only arrives after a leading one
    a_r2_hdr_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !first) |-> (idx_q != '0));

endmodule

// File: rtl/sip_history.sv
`timescale 1ns/1ps
module sip_history #(
    parameter int unsigned DEPTH = 5,
    parameter int unsigned W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic [W-1:0]     din,
    output logic [DEPTH*W-1:0] hist
);
    logic [W-1:0] tap [DEPTH+1];

    assign tap[0] = din;

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                q <= '0;
            end else if (push) begin
                q <= tap[k];
            end
        end
        assign tap[k+1]       = q;
        assign hist[k*W +: W] = q;
    end

    // R11: start of block and a data byte never coincide
    a_r11_push_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && clear));

endmodule

// File: rtl/sip_count.sv
`timescale 1ns/1ps
module sip_count #(
    parameter int unsigned SIZE_W = 16,
    parameter int unsigned ADD_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              add_en,
    input  logic [ADD_W-1:0]  add,
    input  logic [SIZE_W-1:0] size,
    output logic              reach
);
    localparam int unsigned CNT_W   = SIZE_W + 1;
    localparam int unsigned MAX_ADD = (1 << ADD_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   sum;

    assign sum   = {1'b0, cnt_q} + (CNT_W+1)'(add);
    assign reach = sum >= (CNT_W+1)'(size);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (add_en) begin
            cnt_q <= sum[CNT_W-1:0];
        end
    end

    // R7: the count never runs past the size by more than one item
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cnt_q} <= (CNT_W+1)'(size) + (CNT_W+1)'(MAX_ADD)));

endmodule

// File: rtl/sip_fsm.sv
`timescale 1ns/1ps
module sip_fsm
    import sip_pkg::*;
#(
    parameter int unsigned CTRL_BITS = 16,
    parameter int unsigned ADD_W     = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sof,
    input  logic [7:0]         in_data,
    output logic               in_ready,
    input  logic               hdr_last,
    input  logic               hdr_compressed,
    input  logic               hdr_size_zero,
    input  logic               reach,
    output logic               hdr_take,
    output logic               hdr_first,
    output logic               hist_clear,
    output logic               hist_push,
    output logic               cnt_clear,
    output logic               cnt_add_en,
    output logic [ADD_W-1:0]   cnt_add,
    output logic               out_valid,
    output logic [1:0]         out_kind,
    output logic [7:0]         out_byte,
    output logic [INDEX_W-1:0] out_index,
    output logic [LEN_CODE_W-1:0] out_len,
    output logic               out_eob
);
    localparam int unsigned CTRL_BYTES = CTRL_BITS / 8;
    localparam int unsigned CI_W       = (CTRL_BYTES > 1) ? $clog2(CTRL_BYTES) : 1;
    localparam int unsigned BI_W       = $clog2(CTRL_BITS);

    parse_state_e          state, state_d;
    logic [CTRL_BITS-1:0]  ctl_word;
    logic [CI_W-1:0]       ctl_idx, ctl_idx_d;
    logic [BI_W-1:0]       bit_idx, bit_idx_d;
    logic [7:0]            first_q;
    logic                  ctl_wr, first_wr, finish, accept;
    logic                  emit, eob_d;
    item_kind_e            kind_d;
    logic [INDEX_W-1:0]    idx_d;
    logic [LEN_CODE_W-1:0] len_d;
    logic                  cur_bit;
    logic [LEN_CODE_W-1:0] copy_len;

    assign in_ready = (state != S_CLEAR);
    assign accept   = in_valid && in_ready;
    assign cur_bit  = ctl_word[bit_idx];
    assign copy_len = first_q[7:4];

    always_comb begin
        state_d    = state;
        ctl_idx_d  = ctl_idx;
        bit_idx_d  = bit_idx;
        hdr_take   = 1'b0;
        hdr_first  = 1'b0;
        hist_clear = 1'b0;
        hist_push  = 1'b0;
        cnt_clear  = 1'b0;
        cnt_add_en = 1'b0;
        cnt_add    = '0;
        ctl_wr     = 1'b0;
        first_wr   = 1'b0;
        finish     = 1'b0;
        emit       = 1'b0;
        eob_d      = 1'b0;
        kind_d     = K_LIT;
        idx_d      = '0;
        len_d      = '0;
        unique case (state)
            S_CLEAR: state_d = S_SEEK;
            default: begin
                if (accept && in_sof) begin
                    hdr_take   = 1'b1;
                    hdr_first  = 1'b1;
                    hist_clear = 1'b1;
                    cnt_clear  = 1'b1;
                    state_d    = S_HDR;
                end else if (accept) begin
                    case (state)
                        S_HDR: begin
                            hdr_take = 1'b1;
                            if (hdr_last) begin
                                if (hdr_size_zero) begin
                                    emit    = 1'b1;
                                    kind_d  = K_END;
                                    eob_d   = 1'b1;
                                    state_d = S_SEEK;
                                end else if (hdr_compressed) begin
                                    ctl_idx_d = '0;
                                    state_d   = S_CTL;
                                end else begin
                                    state_d = S_RAW;
                                end
                            end
                        end
                        S_CTL: begin
                            ctl_wr = 1'b1;
                            emit   = 1'b1;
                            kind_d = K_CTRL;
                            if (ctl_idx == CI_W'(CTRL_BYTES - 1)) begin
                                bit_idx_d = '0;
                                state_d   = S_ITEM;
                            end else begin
                                ctl_idx_d = ctl_idx + 1'b1;
                            end
                        end
                        S_ITEM: begin
                            hist_push = 1'b1;
                            if (!cur_bit) begin
                                emit       = 1'b1;
                                kind_d     = K_LIT;
                                cnt_add_en = 1'b1;
                                cnt_add    = ADD_W'(1);
                                finish     = 1'b1;
                            end else begin
                                first_wr = 1'b1;
                                state_d  = S_COPY2;
                            end
                        end
                        S_COPY2: begin
                            hist_push  = 1'b1;
                            emit       = 1'b1;
                            kind_d     = K_COPY;
                            idx_d      = {first_q[3:0], in_data};
                            len_d      = copy_len;
                            cnt_add_en = 1'b1;
                            cnt_add    = ADD_W'(copy_len) + ADD_W'(MIN_COPY);
                            finish     = 1'b1;
                        end
                        S_RAW: begin
                            hist_push  = 1'b1;
                            emit       = 1'b1;
                            kind_d     = K_LIT;
                            cnt_add_en = 1'b1;
                            cnt_add    = ADD_W'(1);
                            if (reach) begin
                                eob_d   = 1'b1;
                                state_d = S_SEEK;
                            end
                        end
                        default: ;
                    endcase
                    if (finish) begin
                        if (reach) begin
                            eob_d   = 1'b1;
                            state_d = S_SEEK;
                        end else if (bit_idx == BI_W'(CTRL_BITS - 1)) begin
                            ctl_idx_d = '0;
                            state_d   = S_CTL;
                        end else begin
                            bit_idx_d = bit_idx + 1'b1;
                            state_d   = S_ITEM;
                        end
                    end
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_CLEAR;
            ctl_idx  <= '0;
            bit_idx  <= '0;
            ctl_word <= '0;
            first_q  <= '0;
        end else begin
            state   <= state_d;
            ctl_idx <= ctl_idx_d;
            bit_idx <= bit_idx_d;
            if (ctl_wr) begin
                ctl_word[8*ctl_idx +: 8] <= in_data;
            end
            if (first_wr) begin
                first_q <= in_data;
            end
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_kind  <= K_LIT;
            out_byte  <= '0;
            out_index <= '0;
            out_len   <= '0;
            out_eob   <= 1'b0;
        end else begin
            out_valid <= emit;
            out_eob   <= eob_d;
            if (emit) begin
                out_kind  <= kind_d;
                out_byte  <= in_data;
                out_index <= idx_d;
                out_len   <= len_d;
            end
        end
    end

    a_r7_eob_has_item: assert property (@(posedge clk) disable iff (!rst_n)
        out_eob |-> out_valid);

    a_r8_quiet_after_eob: assert property (@(posedge clk) disable iff (!rst_n)
        out_eob |=> !out_valid);

    a_r10_end_is_last: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == K_END) |-> out_eob);

    a_r1_ready_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CLEAR) |=> in_ready);

endmodule

// File: rtl/stream_item_parser.sv
`timescale 1ns/1ps
module stream_item_parser
    import sip_pkg::*;
#(
    parameter int unsigned HDR_BYTES  = 8,
    parameter int unsigned SIZE_BYTES = 2,
    parameter int unsigned CTRL_BITS  = 16,
    parameter int unsigned HIST_DEPTH = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [7:0]              in_data,
    input  logic                    in_sof,
    output logic                    out_valid,
    output logic [1:0]              out_kind,
    output logic [7:0]              out_byte,
    output logic [11:0]             out_index,
    output logic [3:0]              out_len,
    output logic                    out_eob,
    output logic [HIST_DEPTH*8-1:0] hist_bytes
);
    localparam int unsigned SIZE_W = 8 * SIZE_BYTES;
    localparam int unsigned ADD_W  = $clog2((1 << LEN_CODE_W) + MIN_COPY);

    logic              hdr_take, hdr_first, hdr_last, hdr_comp;
    logic [SIZE_W-1:0] hdr_size;
    logic              hist_clear, hist_push;
    logic              cnt_clear, cnt_add_en, reach;
    logic [ADD_W-1:0]  cnt_add;

    sip_header #(
        .HDR_BYTES  (HDR_BYTES),
        .SIZE_BYTES (SIZE_BYTES)
    ) u_hdr (
        .clk          (clk),
        .rst_n        (rst_n),
        .take         (hdr_take),
        .first        (hdr_first),
        .byte_in      (in_data),
        .last         (hdr_last),
        .size_o       (hdr_size),
        .compressed_o (hdr_comp)
    );

    sip_count #(
        .SIZE_W (SIZE_W),
        .ADD_W  (ADD_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (cnt_clear),
        .add_en (cnt_add_en),
        .add    (cnt_add),
        .size   (hdr_size),
        .reach  (reach)
    );

    sip_history #(
        .DEPTH (HIST_DEPTH),
        .W     (8)
    ) u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (hist_clear),
        .push  (hist_push),
        .din   (in_data),
        .hist  (hist_bytes)
    );

    sip_fsm #(
        .CTRL_BITS (CTRL_BITS),
        .ADD_W     (ADD_W)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_sof         (in_sof),
        .in_data        (in_data),
        .in_ready       (in_ready),
        .hdr_last       (hdr_last),
        .hdr_compressed (hdr_comp),
        .hdr_size_zero  (hdr_size == '0),
        .reach          (reach),
        .hdr_take       (hdr_take),
        .hdr_first      (hdr_first),
        .hist_clear     (hist_clear),
        .hist_push      (hist_push),
        .cnt_clear      (cnt_clear),
        .cnt_add_en     (cnt_add_en),
        .cnt_add        (cnt_add),
        .out_valid      (out_valid),
        .out_kind       (out_kind),
        .out_byte       (out_byte),
        .out_index      (out_index),
        .out_len        (out_len),
        .out_eob        (out_eob)
    );

endmodule

// File: tb/sim_stream_item_parser.sv
`timescale 1ns/1ps
module sim_stream_item_parser;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready;
    logic        out_valid;
    logic [1:0]  out_kind;
    logic [7:0]  out_byte;
    logic [11:0] out_index;
    logic [3:0]  out_len;
    logic        out_eob;
    logic [39:0] hist_bytes;

    always #2.5 clk = ~clk;

    stream_item_parser u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .in_sof     (in_sof),
        .out_valid  (out_valid),
        .out_kind   (out_kind),
        .out_byte   (out_byte),
        .out_index  (out_index),
        .out_len    (out_len),
        .out_eob    (out_eob),
        .hist_bytes (hist_bytes)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // stream under construction and the item expected per byte
    logic [7:0]  sbuf    [0:1023];
    bit          sb_sof  [0:1023];
    bit          sb_beat [0:1023];
    logic [1:0]  sb_kind [0:1023];
    logic [11:0] sb_idx  [0:1023];
    logic [3:0]  sb_len  [0:1023];
    bit          sb_eob  [0:1023];
    int          wp;
    bit          act;
    int          run;
    int          bsize;
    logic [39:0] exp_hist;

    task automatic chk(string tag, longint act_v, longint exp_v);
        n_tests++;
        if (act_v != exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
        end
    endtask

    function automatic logic [7:0] lit_of(int i, int seed);
        return 8'((i * 37 + seed * 11 + 5) & 255);
    endfunction
    function automatic logic [3:0] len_of(int i, int seed);
        return 4'((i * 7 + seed) % 16);
    endfunction
    function automatic logic [11:0] idx_of(int i, int seed);
        return 12'((i * 291 + seed * 53) % 4096);
    endfunction
    function automatic bit cbit(int i, logic [15:0] w0, logic [15:0] w1);
        return (i < 16) ? w0[i] : w1[i-16];
    endfunction

    task automatic put(logic [7:0] b);
        sbuf[wp]    = b;
        sb_sof[wp]  = (wp == 0);
        sb_beat[wp] = 1'b0;
        sb_kind[wp] = 2'd0;
        sb_idx[wp]  = '0;
        sb_len[wp]  = '0;
        sb_eob[wp]  = 1'b0;
        wp++;
    endtask

    task automatic beat(logic [1:0] k);
        sb_beat[wp-1] = 1'b1;
        sb_kind[wp-1] = k;
    endtask

    task automatic hist_in(logic [7:0] b);
        exp_hist = {exp_hist[31:0], b};
    endtask

    // R7: literal counts 1, copy counts length code + 3
    task automatic counted(int n);
        run += n;
        if (run >= bsize) begin
            sb_eob[wp-1] = 1'b1;
            act = 1'b0;
        end
    endtask

    // R2: size little-endian in bytes 0..1, flag in bit 0 of byte 2
    task automatic header(int size, bit comp);
        wp = 0; act = 1'b1; run = 0; bsize = size; exp_hist = '0;
        put(8'(size & 255));
        put(8'((size >> 8) & 255));
        put(8'h60 | {7'd0, comp});
        for (int i = 0; i < 5; i++) put(8'hC0 + 8'(i));
        if (size == 0) begin
            beat(2'd3);
            sb_eob[wp-1] = 1'b1;
            act = 1'b0;
        end
    endtask

    task automatic build_raw(int n, int size, int seed);
        header(size, 1'b0);
        for (int i = 0; i < n; i++) begin
            put(lit_of(i, seed));
            if (act) begin
                beat(2'd0);
                hist_in(lit_of(i, seed));
                counted(1);
            end
        end
    endtask

    task automatic build_comp(int nitems, logic [15:0] w0, logic [15:0] w1,
                              int stop_item, int shave_req, int seed);
        int cum;
        int last_c;
        cum = 0;
        last_c = 1;
        for (int i = 0; i <= stop_item; i++) begin
            last_c = cbit(i, w0, w1) ? (int'(len_of(i, seed)) + 3) : 1;
            cum += last_c;
        end
        header(cum - (shave_req % last_c), 1'b1);
        for (int i = 0; i < nitems; i++) begin
            if (i % 16 == 0) begin
                logic [15:0] w;
                w = (i < 16) ? w0 : w1;
                put(w[7:0]);
                if (act) beat(2'd2);
                put(w[15:8]);
                if (act) beat(2'd2);
            end
            if (!cbit(i, w0, w1)) begin
                put(lit_of(i, seed));
                if (act) begin
                    beat(2'd0);
                    hist_in(lit_of(i, seed));
                    counted(1);
                end
            end else begin
                logic [11:0] ix;
                logic [3:0]  ln;
                ix = idx_of(i, seed);
                ln = len_of(i, seed);
                put({ln, ix[11:8]});
                if (act) hist_in({ln, ix[11:8]});
                put(ix[7:0]);
                if (act) begin
                    beat(2'd1);
                    sb_idx[wp-1] = ix;
                    sb_len[wp-1] = ln;
                    hist_in(ix[7:0]);
                    counted(int'(ln) + 3);
                end
            end
        end
    endtask

    function automatic string kind_tag(logic [1:0] k);
        case (k)
            2'd0: return "R5";
            2'd1: return "R6";
            2'd2: return "R4";
            default: return "R10";
        endcase
    endfunction

    // called at a negedge; the item is sampled at the next negedge (R12)
    task automatic send_byte(int p, bit gap);
        in_valid = 1'b1;
        in_data  = sbuf[p];
        in_sof   = sb_sof[p];
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        chk((p < 8) ? "R2" : "R12", longint'(out_valid), longint'(sb_beat[p]));
        if (sb_beat[p] && out_valid) begin
            chk(kind_tag(sb_kind[p]), longint'(out_kind), longint'(sb_kind[p]));
            if (sb_kind[p] == 2'd0 || sb_kind[p] == 2'd2)
                chk("R3", longint'(out_byte), longint'(sbuf[p]));
            if (sb_kind[p] == 2'd1) begin
                chk("R6", longint'(out_index), longint'(sb_idx[p]));
                chk("R6", longint'(out_len), longint'(sb_len[p]));
            end
            chk("R7", longint'(out_eob), longint'(sb_eob[p]));
        end
        if (gap) begin
            @(posedge clk);
            @(negedge clk);
            chk("R12", longint'(out_valid), 0);
        end
    endtask

    task automatic send_stream(int n, bit gaps);
        for (int p = 0; p < n; p++) send_byte(p, gaps && (p % 3 == 1));
    endtask

    // R8: trailing bytes without a start flag are dropped
    task automatic send_junk(int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_data  = 8'h3C + 8'(i);
            in_sof   = 1'b0;
            @(posedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            chk("R8", longint'(out_valid), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", longint'(out_valid), 0);
        rst_n = 1'b1;
        #1;
        chk("R1", longint'(in_ready), 0);
        @(negedge clk);
        chk("R1", longint'(in_ready), 1);
        chk("R1", longint'(out_valid), 0);

        // R3: stored block, size 6, 4 surplus bytes dropped
        build_raw(10, 6, 1);
        send_stream(wp, 1'b0);
        chk("R11", longint'(hist_bytes), longint'(exp_hist));

        // R10: empty block
        build_raw(3, 0, 2);
        send_stream(wp, 1'b0);
        chk("R11", longint'(hist_bytes), longint'(exp_hist));

        // R5 R7: sweep of flag patterns, short last group, mid-group end
        for (int k = 0; k < 24; k++) begin
            logic [15:0] w0, w1;
            int ni;
            case (k)
                0: begin w0 = 16'h0000; w1 = 16'h0000; end
                1: begin w0 = 16'hFFFF; w1 = 16'hFFFF; end
                2: begin w0 = 16'hAAAA; w1 = 16'h5555; end
                3: begin w0 = 16'h5555; w1 = 16'hAAAA; end
                default: begin
                    w0 = 16'((k * 40503 + 77) & 16'hFFFF);
                    w1 = 16'((k * 12345 + 9) & 16'hFFFF);
                end
            endcase
            ni = 17 + (k % 16);
            build_comp(ni, w0, w1, ni - 1 - (k % 4), k % 3, k + 3);
            send_stream(wp, k[0]);
            chk("R11", longint'(hist_bytes), longint'(exp_hist));
        end

        // R7: end in the middle of the first group
        build_comp(32, 16'h0F0C, 16'h0000, 5, 0, 7);
        send_stream(wp, 1'b0);
        chk("R11", longint'(hist_bytes), longint'(exp_hist));
        send_junk(4);
        chk("R8", longint'(hist_bytes), longint'(exp_hist));

        // R9: abort inside the header, then a full block
        build_comp(24, 16'h1234, 16'h00FF, 23, 0, 9);
        send_stream(5, 1'b0);
        build_comp(20, 16'h8421, 16'h000F, 19, 1, 10);
        send_stream(wp, 1'b0);
        chk("R9", longint'(hist_bytes), longint'(exp_hist));

        // R9: abort in the data of a compressed block, then a stored block
        build_comp(32, 16'h00F0, 16'h0F00, 31, 0, 11);
        send_stream(20, 1'b0);
        build_raw(3, 3, 12);
        send_stream(wp, 1'b1);
        chk("R9", longint'(hist_bytes), longint'(exp_hist));

        repeat (3) @(negedge clk);
        chk("R8", longint'(out_valid), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R12 watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule